// File: doc/BRIEF.md
# Row-Hit-First Memory Request Scheduler

This block sits between the request intake of a multi-bank memory controller and its per-bank command sequencers. It keeps two small pending pools, one for reads and one for writes. Every entry records a bank, a row, a column and how many cycles it has been waiting. Each cycle the block looks at the state of every bank, which is whether the bank is busy and which row, if any, it holds open. It then grants at most one pending request and removes it from its pool in the same cycle. The granted request appears on a registered issue port one clock later.

Under the default policy, requests that target the row already open in their bank win over requests that need a row change. Within each class the one that has waited longest goes first. Requests to a busy bank are passed over, so a later request to an idle bank can proceed ahead of them. Reads normally take precedence and writes wait in their own pool. When the write pool fills to a high-water mark, writes take precedence until the pool drops below a low-water mark. A mode input turns off the row-hit preference and leaves plain oldest-eligible-first ordering.

Top module: `mem_sched_frfcfs`

## Requirements
- R1: After reset no request is issued (`iss_valid` low) and both `rd_req_ready` and `wr_req_ready` are high.
- R2: With `fcfs_mode` high, the longest-waiting request whose bank is not busy is granted, whether or not it hits the open row.
- R3: With `fcfs_mode` low, a request whose row equals the open row of its bank (`bank_open_vld` bit set and matching row) is granted ahead of any older request that needs a row change, and `iss_row_hit` is 1 for it.
- R4: Among several eligible row-hit requests, the one that has waited longest is granted first.
- R5: A request whose `bank_busy` bit is set is never granted. The next-oldest eligible request is granted instead, and nothing is issued when every pending request targets a busy bank.
- R6: When no eligible request hits its open row, the oldest eligible row-miss request is granted, with `iss_row_hit` 0.
- R7: Outside drain mode, a write is not granted while any read is pending, even if every pending read targets a busy bank. A write is granted once the read pool is empty.
- R8: When the write pool holds at least WR_HI_MARK (default 3) entries, eligible writes are granted ahead of reads. This continues until the pool holds fewer than WR_LO_MARK (default 1) entries. If no write is eligible during this period, an eligible read may still be granted.
- R9: A pool that is full deasserts its ready, and a request offered to it then is dropped. Ready returns once an entry has been granted.
- R10: A request enqueued at rising edge k is granted at the earliest at edge k+1, when its fields appear on the issue port. Each request is issued exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fcfs_mode | input | 1 | 1: oldest-eligible-first; 0: row hits first |
| rd_req_valid | input | 1 | Read request offered |
| rd_req_ready | output | 1 | Read pool has a free slot |
| rd_req_bank | input | BANK_W | Read target bank |
| rd_req_row | input | ROW_W | Read target row |
| rd_req_col | input | COL_W | Read target column |
| wr_req_valid | input | 1 | Write request offered |
| wr_req_ready | output | 1 | Write pool has a free slot |
| wr_req_bank | input | BANK_W | Write target bank |
| wr_req_row | input | ROW_W | Write target row |
| wr_req_col | input | COL_W | Write target column |
| bank_busy | input | NUM_BANKS | Bank cannot accept a request this cycle |
| bank_open_vld | input | NUM_BANKS | Bank has a row open |
| bank_open_row | input | NUM_BANKS*ROW_W | Open row of each bank, bank 0 in the low bits |
| iss_valid | output | 1 | A request was granted in the previous cycle |
| iss_write | output | 1 | Granted request is a write |
| iss_bank | output | BANK_W | Bank of granted request |
| iss_row | output | ROW_W | Row of granted request |
| iss_col | output | COL_W | Column of granted request |
| iss_row_hit | output | 1 | Granted request hit the open row |

## Verification
A grant is chosen from pool and bank state during one cycle and shows on the issue port after the next rising edge. Enqueues and changes to the bank inputs are applied at a falling edge, and the issue port is read at the following falling edge. Each later grant follows one cycle apart. Requests are loaded while every bank reports busy, so none can leave early. The bench then releases the banks in chosen patterns and checks the exact order of grants cycle by cycle. It confirms that the issue port stays idle in the cycles where a busy bank, a pending read or a dropped request should prevent a grant.

// File: rtl/frfcfs_pkg.sv
package frfcfs_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RD   = 2'd1,
    SRC_WR   = 2'd2
  } grant_src_e;
endpackage

// File: rtl/sched_queue.sv
module sched_queue #(
  parameter int DEPTH  = 4,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  parameter int AGE_W  = 6
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               enq_valid,
  output logic                               enq_ready,
  input  logic [BANK_W-1:0]                  enq_bank,
  input  logic [ROW_W-1:0]                   enq_row,
  input  logic [COL_W-1:0]                   enq_col,
  input  logic                               deq_en,
  input  logic [$clog2(DEPTH)-1:0]           deq_idx,
  output logic [DEPTH-1:0]                   ent_valid,
  output logic [DEPTH-1:0][BANK_W-1:0]       ent_bank,
  output logic [DEPTH-1:0][ROW_W-1:0]        ent_row,
  output logic [DEPTH-1:0][COL_W-1:0]        ent_col,
  output logic [DEPTH-1:0][AGE_W-1:0]        ent_age,
  output logic [$clog2(DEPTH+1)-1:0]         count
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             free_found;
  logic [IDX_W-1:0] free_idx;

  // lowest-numbered empty slot
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign enq_ready = free_found;

  always_comb begin
    count = '0;
    for (int i = 0; i < DEPTH; i++) count = count + CNT_W'(ent_valid[i]);
  end

  // occupancy and waiting time
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= '0;
      ent_age   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ent_valid[i] && (ent_age[i] != {AGE_W{1'b1}}))
          ent_age[i] <= ent_age[i] + 1'b1;
      end
      if (deq_en) ent_valid[deq_idx] <= 1'b0;
      if (enq_valid && free_found) begin
        ent_valid[free_idx] <= 1'b1;
        ent_age[free_idx]   <= '0;
      end
    end
  end

  // payload store, no reset needed
  always_ff @(posedge clk) begin
    if (enq_valid && free_found) begin
      ent_bank[free_idx] <= enq_bank;
      ent_row[free_idx]  <= enq_row;
      ent_col[free_idx]  <= enq_col;
    end
  end

  a_r10_deq_live: assert property (@(posedge clk) disable iff (rst)
    deq_en |-> ent_valid[deq_idx]);

  a_r9_full_drops: assert property (@(posedge clk) disable iff (rst)
    (enq_valid && !enq_ready && !deq_en) |=> $stable(ent_valid));
endmodule

// File: rtl/sched_pick.sv
module sched_pick #(
  parameter int DEPTH     = 4,
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 8,
  parameter int AGE_W     = 6
) (
  input  logic [DEPTH-1:0]                 ent_valid,
  input  logic [DEPTH-1:0][BANK_W-1:0]     ent_bank,
  input  logic [DEPTH-1:0][ROW_W-1:0]      ent_row,
  input  logic [DEPTH-1:0][AGE_W-1:0]      ent_age,
  input  logic [NUM_BANKS-1:0]             bank_busy,
  input  logic [NUM_BANKS-1:0]             bank_open_vld,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0]  bank_open_row,
  input  logic                             fcfs_mode,
  output logic                             found,
  output logic [$clog2(DEPTH)-1:0]         idx,
  output logic                             hit,
  output logic                             hit_any
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0] elig, row_hit;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      assign elig[g]    = ent_valid[g] && !bank_busy[ent_bank[g]];
      assign row_hit[g] = bank_open_vld[ent_bank[g]] &&
                          (bank_open_row[ent_bank[g]] == ent_row[g]);
    end
  endgenerate

  logic             any_f, hit_f;
  logic [IDX_W-1:0] any_i, hit_i;
  logic [AGE_W-1:0] any_a, hit_a;

  // strict greater-than keeps the lower index on equal age
  always_comb begin
    any_f = 1'b0; any_i = '0; any_a = '0;
    hit_f = 1'b0; hit_i = '0; hit_a = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (elig[i] && (!any_f || ent_age[i] > any_a)) begin
        any_f = 1'b1; any_i = IDX_W'(i); any_a = ent_age[i];
      end
      if (elig[i] && row_hit[i] && (!hit_f || ent_age[i] > hit_a)) begin
        hit_f = 1'b1; hit_i = IDX_W'(i); hit_a = ent_age[i];
      end
    end
    if (!fcfs_mode && hit_f) begin
      found = 1'b1;
      idx   = hit_i;
    end else begin
      found = any_f;
      idx   = any_i;
    end
    hit     = row_hit[idx];
    hit_any = hit_f;
  end
endmodule

// File: rtl/mem_sched_frfcfs.sv
module mem_sched_frfcfs #(
  parameter int NUM_BANKS  = 4,
  parameter int ROW_W      = 8,
  parameter int COL_W      = 6,
  parameter int RD_DEPTH   = 4,
  parameter int WR_DEPTH   = 4,
  parameter int WR_HI_MARK = 3,
  parameter int WR_LO_MARK = 1,
  parameter int AGE_W      = 6,
  parameter int BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fcfs_mode,
  input  logic                       rd_req_valid,
  output logic                       rd_req_ready,
  input  logic [BANK_W-1:0]          rd_req_bank,
  input  logic [ROW_W-1:0]           rd_req_row,
  input  logic [COL_W-1:0]           rd_req_col,
  input  logic                       wr_req_valid,
  output logic                       wr_req_ready,
  input  logic [BANK_W-1:0]          wr_req_bank,
  input  logic [ROW_W-1:0]           wr_req_row,
  input  logic [COL_W-1:0]           wr_req_col,
  input  logic [NUM_BANKS-1:0]       bank_busy,
  input  logic [NUM_BANKS-1:0]       bank_open_vld,
  input  logic [NUM_BANKS*ROW_W-1:0] bank_open_row,
  output logic                       iss_valid,
  output logic                       iss_write,
  output logic [BANK_W-1:0]          iss_bank,
  output logic [ROW_W-1:0]           iss_row,
  output logic [COL_W-1:0]           iss_col,
  output logic                       iss_row_hit
);
  import frfcfs_pkg::*;

  localparam int RIDX_W = $clog2(RD_DEPTH);
  localparam int WIDX_W = $clog2(WR_DEPTH);
  localparam int RCNT_W = $clog2(RD_DEPTH + 1);
  localparam int WCNT_W = $clog2(WR_DEPTH + 1);
  localparam logic [WCNT_W-1:0] HI_C = WCNT_W'(WR_HI_MARK);
  localparam logic [WCNT_W-1:0] LO_C = WCNT_W'(WR_LO_MARK);

  logic [NUM_BANKS-1:0][ROW_W-1:0] open_row_arr;
  assign open_row_arr = bank_open_row;

  logic [RD_DEPTH-1:0]               rq_valid;
  logic [RD_DEPTH-1:0][BANK_W-1:0]   rq_bank;
  logic [RD_DEPTH-1:0][ROW_W-1:0]    rq_row;
  logic [RD_DEPTH-1:0][COL_W-1:0]    rq_col;
  logic [RD_DEPTH-1:0][AGE_W-1:0]    rq_age;
  logic [RCNT_W-1:0]                 rq_cnt;
  logic [WR_DEPTH-1:0]               wq_valid;
  logic [WR_DEPTH-1:0][BANK_W-1:0]   wq_bank;
  logic [WR_DEPTH-1:0][ROW_W-1:0]    wq_row;
  logic [WR_DEPTH-1:0][COL_W-1:0]    wq_col;
  logic [WR_DEPTH-1:0][AGE_W-1:0]    wq_age;
  logic [WCNT_W-1:0]                 wq_cnt;

  logic              r_found, r_hit, r_hit_any;
  logic [RIDX_W-1:0] r_idx;
  logic              w_found, w_hit, w_hit_any;
  logic [WIDX_W-1:0] w_idx;
  grant_src_e        src;

  sched_queue #(.DEPTH(RD_DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .AGE_W(AGE_W)) u_rdq (
    .clk(clk), .rst(rst),
    .enq_valid(rd_req_valid), .enq_ready(rd_req_ready),
    .enq_bank(rd_req_bank), .enq_row(rd_req_row), .enq_col(rd_req_col),
    .deq_en(src == SRC_RD), .deq_idx(r_idx),
    .ent_valid(rq_valid), .ent_bank(rq_bank), .ent_row(rq_row),
    .ent_col(rq_col), .ent_age(rq_age), .count(rq_cnt));

  sched_queue #(.DEPTH(WR_DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .AGE_W(AGE_W)) u_wrq (
    .clk(clk), .rst(rst),
    .enq_valid(wr_req_valid), .enq_ready(wr_req_ready),
    .enq_bank(wr_req_bank), .enq_row(wr_req_row), .enq_col(wr_req_col),
    .deq_en(src == SRC_WR), .deq_idx(w_idx),
    .ent_valid(wq_valid), .ent_bank(wq_bank), .ent_row(wq_row),
    .ent_col(wq_col), .ent_age(wq_age), .count(wq_cnt));

  sched_pick #(.DEPTH(RD_DEPTH), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .AGE_W(AGE_W)) u_rpick (
    .ent_valid(rq_valid), .ent_bank(rq_bank), .ent_row(rq_row), .ent_age(rq_age),
    .bank_busy(bank_busy), .bank_open_vld(bank_open_vld), .bank_open_row(open_row_arr),
    .fcfs_mode(fcfs_mode), .found(r_found), .idx(r_idx), .hit(r_hit), .hit_any(r_hit_any));

  sched_pick #(.DEPTH(WR_DEPTH), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .AGE_W(AGE_W)) u_wpick (
    .ent_valid(wq_valid), .ent_bank(wq_bank), .ent_row(wq_row), .ent_age(wq_age),
    .bank_busy(bank_busy), .bank_open_vld(bank_open_vld), .bank_open_row(open_row_arr),
    .fcfs_mode(fcfs_mode), .found(w_found), .idx(w_idx), .hit(w_hit), .hit_any(w_hit_any));

  // write drain hysteresis
  logic drain_q, drain_eff, rd_pending;
  assign rd_pending = (rq_cnt != '0);
  assign drain_eff  = (wq_cnt >= HI_C) || (drain_q && (wq_cnt >= LO_C));

  always_comb begin
    src = SRC_NONE;
    if (drain_eff && w_found)        src = SRC_WR;
    else if (r_found)                src = SRC_RD;
    else if (!rd_pending && w_found) src = SRC_WR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drain_q     <= 1'b0;
      iss_valid   <= 1'b0;
      iss_write   <= 1'b0;
      iss_bank    <= '0;
      iss_row     <= '0;
      iss_col     <= '0;
      iss_row_hit <= 1'b0;
    end else begin
      drain_q   <= drain_eff;
      iss_valid <= (src != SRC_NONE);
      iss_write <= (src == SRC_WR);
      if (src == SRC_WR) begin
        iss_bank    <= wq_bank[w_idx];
        iss_row     <= wq_row[w_idx];
        iss_col     <= wq_col[w_idx];
        iss_row_hit <= w_hit;
      end else begin
        iss_bank    <= rq_bank[r_idx];
        iss_row     <= rq_row[r_idx];
        iss_col     <= rq_col[r_idx];
        iss_row_hit <= r_hit;
      end
    end
  end

  // one-cycle copies of the decision context, used only by the properties
  logic [NUM_BANKS-1:0] chk_busy_q;
  logic chk_rpend_q, chk_drain_q, chk_fcfs_q, chk_rhit_q, chk_whit_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_busy_q  <= '0;
      chk_rpend_q <= 1'b0;
      chk_drain_q <= 1'b0;
      chk_fcfs_q  <= 1'b0;
      chk_rhit_q  <= 1'b0;
      chk_whit_q  <= 1'b0;
    end else begin
      chk_busy_q  <= bank_busy;
      chk_rpend_q <= rd_pending;
      chk_drain_q <= drain_eff;
      chk_fcfs_q  <= fcfs_mode;
      chk_rhit_q  <= r_hit_any;
      chk_whit_q  <= w_hit_any;
    end
  end

  a_r5_bank_free: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> !chk_busy_q[iss_bank]);

  a_r7_write_defer: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_write) |-> (chk_drain_q || !chk_rpend_q));

  a_r3_read_hit_first: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_write && !iss_row_hit && !chk_fcfs_q) |-> !chk_rhit_q);

  a_r3_write_hit_first: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_write && !iss_row_hit && !chk_fcfs_q) |-> !chk_whit_q);
endmodule

// File: tb/tb_mem_sched_frfcfs.sv
module tb_mem_sched_frfcfs;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int RW = 8;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fcfs_mode = 1'b0;
  logic rd_req_valid = 1'b0, wr_req_valid = 1'b0;
  logic rd_req_ready, wr_req_ready;
  logic [1:0] rd_req_bank = '0, wr_req_bank = '0;
  logic [RW-1:0] rd_req_row = '0, wr_req_row = '0;
  logic [CW-1:0] rd_req_col = '0, wr_req_col = '0;
  logic [NB-1:0] bank_busy = '1;
  logic [NB-1:0] bank_open_vld = '0;
  logic [NB*RW-1:0] bank_open_row = '0;
  logic iss_valid, iss_write, iss_row_hit;
  logic [1:0] iss_bank;
  logic [RW-1:0] iss_row;
  logic [CW-1:0] iss_col;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_sched_frfcfs dut (
    .clk(clk), .rst(rst), .fcfs_mode(fcfs_mode),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_bank(rd_req_bank), .rd_req_row(rd_req_row), .rd_req_col(rd_req_col),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
    .wr_req_bank(wr_req_bank), .wr_req_row(wr_req_row), .wr_req_col(wr_req_col),
    .bank_busy(bank_busy), .bank_open_vld(bank_open_vld), .bank_open_row(bank_open_row),
    .iss_valid(iss_valid), .iss_write(iss_write), .iss_bank(iss_bank),
    .iss_row(iss_row), .iss_col(iss_col), .iss_row_hit(iss_row_hit));

  task automatic check(input string req, input logic ok, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic enq(input logic is_wr, input logic [1:0] b, input logic [RW-1:0] r, input logic [CW-1:0] c);
    @(negedge clk);
    if (is_wr) begin
      wr_req_valid = 1'b1; wr_req_bank = b; wr_req_row = r; wr_req_col = c;
    end else begin
      rd_req_valid = 1'b1; rd_req_bank = b; rd_req_row = r; rd_req_col = c;
    end
    @(negedge clk);
    rd_req_valid = 1'b0;
    wr_req_valid = 1'b0;
  endtask

  // waits one cycle, then checks the issue port
  task automatic expect_issue(input string req, input logic w, input logic [1:0] b,
                              input logic [CW-1:0] c, input logic h);
    @(negedge clk);
    check(req, iss_valid && iss_write == w && iss_bank == b && iss_col == c && iss_row_hit == h,
          $sformatf("v%0d w%0d b%0d c%0d h%0d", iss_valid, iss_write, iss_bank, iss_col, iss_row_hit),
          $sformatf("v1 w%0d b%0d c%0d h%0d", w, b, c, h));
  endtask

  task automatic expect_idle(input string req);
    @(negedge clk);
    check(req, !iss_valid, $sformatf("iss_valid=%0d", iss_valid), "iss_valid=0");
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1", !iss_valid && rd_req_ready && wr_req_ready,
          $sformatf("v%0d rr%0d wr%0d", iss_valid, rd_req_ready, wr_req_ready), "v0 rr1 wr1");
  endtask

  task automatic load_mixed();
    // bank0 open row 5, bank1 open row 7
    bank_busy = '1;
    bank_open_vld = 4'b0011;
    bank_open_row = '0;
    bank_open_row[0*RW +: RW] = 8'd5;
    bank_open_row[1*RW +: RW] = 8'd7;
    enq(1'b0, 2'd0, 8'd3, 6'd1);
    enq(1'b0, 2'd1, 8'd9, 6'd2);
    enq(1'b0, 2'd0, 8'd5, 6'd3);
    enq(1'b0, 2'd1, 8'd7, 6'd4);
  endtask

  task automatic test_frfcfs();
    fcfs_mode = 1'b0;
    load_mixed();
    bank_busy = '0;
    expect_issue("R3 hit ahead of older miss", 1'b0, 2'd0, 6'd3, 1'b1);
    expect_issue("R4 older hit next", 1'b0, 2'd1, 6'd4, 1'b1);
    expect_issue("R6 oldest miss", 1'b0, 2'd0, 6'd1, 1'b0);
    expect_issue("R6 next miss", 1'b0, 2'd1, 6'd2, 1'b0);
    expect_idle("R10 each issued once");
  endtask

  task automatic test_fcfs();
    fcfs_mode = 1'b1;
    load_mixed();
    bank_busy = '0;
    expect_issue("R2 oldest first", 1'b0, 2'd0, 6'd1, 1'b0);
    expect_issue("R2 second", 1'b0, 2'd1, 6'd2, 1'b0);
    expect_issue("R2 third", 1'b0, 2'd0, 6'd3, 1'b1);
    expect_issue("R2 fourth", 1'b0, 2'd1, 6'd4, 1'b1);
    expect_idle("R2 drained");
    fcfs_mode = 1'b0;
  endtask

  task automatic test_busy_skip();
    bank_open_vld = '0;
    bank_busy = '1;
    enq(1'b0, 2'd2, 8'd1, 6'd10);
    enq(1'b0, 2'd3, 8'd1, 6'd11);
    enq(1'b0, 2'd2, 8'd1, 6'd12);
    bank_busy = 4'b0100;
    expect_issue("R5 skip busy bank", 1'b0, 2'd3, 6'd11, 1'b0);
    expect_idle("R5 all remaining busy");
    expect_idle("R5 all remaining busy again");
    bank_busy = '0;
    expect_issue("R5 oldest after release", 1'b0, 2'd2, 6'd10, 1'b0);
    expect_issue("R5 last", 1'b0, 2'd2, 6'd12, 1'b0);
    expect_idle("R5 empty");
  endtask

  task automatic test_write_defer();
    bank_busy = '1;
    enq(1'b1, 2'd0, 8'd2, 6'd20);
    enq(1'b0, 2'd1, 8'd2, 6'd21);
    bank_busy = 4'b0010;
    expect_idle("R7 write waits on blocked read");
    expect_idle("R7 write still waits");
    bank_busy = '0;
    expect_issue("R7 read first", 1'b0, 2'd1, 6'd21, 1'b0);
    expect_issue("R7 write after reads", 1'b1, 2'd0, 6'd20, 1'b0);
    enq(1'b1, 2'd2, 8'd2, 6'd22);
    expect_issue("R10 lone write next cycle", 1'b1, 2'd2, 6'd22, 1'b0);
    expect_idle("R10 lone write once");
  endtask

  task automatic test_drain();
    bank_busy = '1;
    enq(1'b0, 2'd0, 8'd4, 6'd30);
    enq(1'b0, 2'd1, 8'd4, 6'd31);
    enq(1'b1, 2'd2, 8'd4, 6'd32);
    enq(1'b1, 2'd3, 8'd4, 6'd33);
    enq(1'b1, 2'd0, 8'd4, 6'd34);
    bank_busy = '0;
    expect_issue("R8 drain w1", 1'b1, 2'd2, 6'd32, 1'b0);
    expect_issue("R8 drain w2", 1'b1, 2'd3, 6'd33, 1'b0);
    expect_issue("R8 drain w3 below high mark", 1'b1, 2'd0, 6'd34, 1'b0);
    expect_issue("R8 reads resume", 1'b0, 2'd0, 6'd30, 1'b0);
    expect_issue("R8 reads resume 2", 1'b0, 2'd1, 6'd31, 1'b0);
    expect_idle("R8 empty");
  endtask

  task automatic test_full();
    bank_busy = '1;
    for (int i = 0; i < 4; i++) enq(1'b0, 2'(i), 8'd6, 6'(40 + i));
    check("R9 full ready low", !rd_req_ready, $sformatf("%0d", rd_req_ready), "0");
    enq(1'b0, 2'd0, 8'd6, 6'd44);
    bank_busy = '0;
    expect_issue("R9 first", 1'b0, 2'd0, 6'd40, 1'b0);
    check("R9 ready back", rd_req_ready, $sformatf("%0d", rd_req_ready), "1");
    expect_issue("R9 second", 1'b0, 2'd1, 6'd41, 1'b0);
    expect_issue("R9 third", 1'b0, 2'd2, 6'd42, 1'b0);
    expect_issue("R9 fourth", 1'b0, 2'd3, 6'd43, 1'b0);
    expect_idle("R9 dropped request absent");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_frfcfs();
    test_fcfs();
    test_busy_skip();
    test_write_defer();
    test_drain();
    test_full();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule